// File: doc/BRIEF.md
# Clock-Sweep Page Frame Victim Selector

This block tracks recent use of a small set of physical page frames and names one frame to evict each time a replacement is asked for. Every frame carries a used bit and a modified bit. A use notification marks a frame as used; a use that is a store also marks it modified. When the caller raises a request, a circular sweep pointer walks the table one frame per clock. A used frame under the pointer loses its used bit and is skipped, which gives it a second chance. The first frame found unused is reported as the victim, together with its modified bit, so the caller knows whether a write-back is due.

A request may ask for a clean-first search. That search makes one read-only lap looking for a frame that is both unused and unmodified. If the lap finds none, the block falls back to the ordinary second-chance sweep from the same starting point. The pointer keeps its place between requests and resumes just past the last victim. This spreads evictions around the table.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset the block is idle (busy and done low), every used and modified bit is clear and the sweep pointer is at frame 0, so a first normal request names frame 0 after one scan cycle.
- R2: A use notification (ref_valid high with ref_idx) sets that frame's used bit; when ref_write is also high it sets the frame's modified bit as well.
- R3: A request is taken only while busy is low, with prefer_clean sampled in the same cycle; busy rises the next cycle. In a normal search each cycle examines the frame at the pointer: if its used bit is set, the bit is cleared and the pointer advances; otherwise that frame is the victim. Busy stays high for k+1 cycles when k frames are examined before the victim.
- R4: The pointer wraps from frame NUM_FRAMES-1 to frame 0.
- R5: Once a victim is chosen the pointer rests on the frame after it, and the next search starts there.
- R6: done is high for exactly one cycle, with victim_idx and victim_dirty valid in that cycle, and busy is already low in that cycle.
- R7: In a clean-first search the block returns the first frame, counted from the pointer, whose used and modified bits are both 0. Used bits are not cleared during this lap.
- R8: If the clean-first lap examines all NUM_FRAMES frames without a match, the block runs a normal search starting from the same pointer. Busy lasts NUM_FRAMES + k + 1 cycles in total.
- R9: victim_dirty gives the victim's modified bit as it stood when the victim was chosen, and that modified bit is cleared on selection.
- R10: A use notification for the frame under the pointer in the same cycle that a normal search clears that frame's used bit wins: the used bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Use notification strobe |
| ref_idx | input | IDX_W | Frame being used |
| ref_write | input | 1 | The use is a store (also sets modified bit) |
| req | input | 1 | Replacement request (accepted while idle) |
| prefer_clean | input | 1 | Clean-first search for this request |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle victim-valid pulse |
| victim_idx | output | IDX_W | Chosen frame |
| victim_dirty | output | 1 | Modified bit of the chosen frame |

## Verification
The assertions assume that ref_idx always names an existing frame and that req is raised only while busy is low. Otherwise the rise of busy after a request would not follow from the request. The stimulus meets both conditions. It pulses req for a single cycle only after the previous done has been seen, and it draws frame numbers within the table size. Use notifications are sent mostly between searches. One directed case deliberately lands a notification in the exact cycle the sweep clears that frame.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAN = 2'd1,
    ST_SWEEP = 2'd2
  } scan_state_e;

  typedef struct packed {
    logic used;
    logic dirty;
  } frame_bits_t;
endpackage

// File: rtl/nru_rst_sync.sv
module nru_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/nru_frame_table.sv
module nru_frame_table
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  set_write,
  input  logic                  clr_used_en,
  input  logic                  clr_dirty_en,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NUM_FRAMES-1:0] used_vec,
  output logic [NUM_FRAMES-1:0] dirty_vec
);
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    frame_bits_t bits_q, bits_d;
    logic        hit_set, hit_clr_used, hit_clr_dirty, upd_en;

    assign hit_set       = set_en && (set_idx == IDX_W'(g));
    assign hit_clr_used  = clr_used_en && (clr_idx == IDX_W'(g));
    assign hit_clr_dirty = clr_dirty_en && (clr_idx == IDX_W'(g));
    assign upd_en        = hit_set | hit_clr_used | hit_clr_dirty;

    // Set beats clear on the same frame in the same cycle.
    always_comb begin
      bits_d = bits_q;
      if (hit_clr_used)  bits_d.used  = 1'b0;
      if (hit_clr_dirty) bits_d.dirty = 1'b0;
      if (hit_set) begin
        bits_d.used = 1'b1;
        if (set_write) bits_d.dirty = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bits_q <= '0;
      else if (upd_en) bits_q <= bits_d;
    end

    assign used_vec[g]  = bits_q.used;
    assign dirty_vec[g] = bits_q.dirty;
  end
endmodule

// File: rtl/nru_sweep_ptr.sv
module nru_sweep_ptr #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/nru_scan_ctrl.sv
module nru_scan_ctrl
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             prefer_clean,
  input  logic [IDX_W-1:0] cur_ptr,
  input  logic             cur_used,
  input  logic             cur_dirty,
  output logic             adv,
  output logic             clr_used,
  output logic             pick,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_dirty
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] lap_q, lap_d;
  logic             lap_en;
  logic             done_q;
  logic [IDX_W-1:0] vidx_q;
  logic             vdirty_q;

  always_comb begin
    state_d  = state_q;
    lap_d    = lap_q;
    lap_en   = 1'b0;
    adv      = 1'b0;
    clr_used = 1'b0;
    pick     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = prefer_clean ? ST_CLEAN : ST_SWEEP;
          lap_d   = '0;
          lap_en  = 1'b1;
        end
      end
      ST_CLEAN: begin
        if (!cur_used && !cur_dirty) begin
          pick = 1'b1;
        end else begin
          adv = 1'b1;
          if (lap_q == LAST) begin
            state_d = ST_SWEEP;
          end else begin
            lap_d  = lap_q + 1'b1;
            lap_en = 1'b1;
          end
        end
      end
      ST_SWEEP: begin
        if (cur_used) begin
          clr_used = 1'b1;
          adv      = 1'b1;
        end else begin
          pick = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (pick) begin
      adv     = 1'b1;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= pick;
      if (lap_en) lap_q <= lap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vidx_q   <= '0;
      vdirty_q <= 1'b0;
    end else if (pick) begin
      vidx_q   <= cur_ptr;
      vdirty_q <= cur_dirty;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign victim_idx   = vidx_q;
  assign victim_dirty = vdirty_q;
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             ref_write,
  input  logic             req,
  input  logic             prefer_clean,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_dirty
);
  logic                  rst_n_int;
  logic [NUM_FRAMES-1:0] used_vec, dirty_vec;
  logic [IDX_W-1:0]      ptr;
  logic                  adv, clr_used, pick;
  logic                  cur_used, cur_dirty;

  nru_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  nru_frame_table #(.NUM_FRAMES(NUM_FRAMES)) u_table (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .set_en       (ref_valid),
    .set_idx      (ref_idx),
    .set_write    (ref_write),
    .clr_used_en  (clr_used),
    .clr_dirty_en (pick),
    .clr_idx      (ptr),
    .used_vec     (used_vec),
    .dirty_vec    (dirty_vec)
  );

  nru_sweep_ptr #(.NUM_FRAMES(NUM_FRAMES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .adv   (adv),
    .ptr   (ptr)
  );

  assign cur_used  = used_vec[ptr];
  assign cur_dirty = dirty_vec[ptr];

  nru_scan_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .req          (req),
    .prefer_clean (prefer_clean),
    .cur_ptr      (ptr),
    .cur_used     (cur_used),
    .cur_dirty    (cur_dirty),
    .adv          (adv),
    .clr_used     (clr_used),
    .pick         (pick),
    .busy         (busy),
    .done         (done),
    .victim_idx   (victim_idx),
    .victim_dirty (victim_dirty)
  );
endmodule

// File: rtl/nru_victim_chk.sv
module nru_victim_chk #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ref_valid,
  input logic [IDX_W-1:0]      ref_idx,
  input logic                  ref_write,
  input logic                  req,
  input logic                  busy,
  input logic                  done,
  input logic [IDX_W-1:0]      victim_idx,
  input logic [IDX_W-1:0]      ptr,
  input logic [NUM_FRAMES-1:0] used_vec,
  input logic [NUM_FRAMES-1:0] dirty_vec
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);

  // R2
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> used_vec[$past(ref_idx)]);

  // R2
  write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_write) |=> dirty_vec[$past(ref_idx)]);

  // R5
  ptr_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ptr == ((victim_idx == LAST) ? '0 : victim_idx + 1'b1)));

  // R5
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(ptr));
endmodule

bind nru_victim_sel nru_victim_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .ref_valid  (ref_valid),
  .ref_idx    (ref_idx),
  .ref_write  (ref_write),
  .req        (req),
  .busy       (busy),
  .done       (done),
  .victim_idx (victim_idx),
  .ptr        (ptr),
  .used_vec   (used_vec),
  .dirty_vec  (dirty_vec)
);

// File: tb/tb_nru_victim_sel.sv
module tb_nru_victim_sel;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic          clk, rst_n;
  logic          ref_valid, ref_write, req, prefer_clean;
  logic [IW-1:0] ref_idx;
  logic          busy, done, victim_dirty;
  logic [IW-1:0] victim_idx;

  nru_victim_sel #(.NUM_FRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .ref_write(ref_write), .req(req), .prefer_clean(prefer_clean),
    .busy(busy), .done(done), .victim_idx(victim_idx), .victim_dirty(victim_dirty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    idx;
    bit    dirty;
    int    cycles;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   errs = 0, checks = 0;
  int   busy_cnt = 0;
  bit   m_used[N];
  bit   m_dirty[N];
  int   m_ptr;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares at each done pulse.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(victim_idx) == e.idx, {e.tag, " victim"}, int'(victim_idx), e.idx);
          chk(victim_dirty == e.dirty, {e.tag, " R9 dirty"}, int'(victim_dirty), int'(e.dirty));
          chk(busy_cnt == e.cycles, {e.tag, " busy cycles"}, busy_cnt, e.cycles);
          chk(!busy, "R6 busy low at done", int'(busy), 0);
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic use_frame(input int f, input bit wr);
    @(negedge clk);
    ref_valid = 1'b1; ref_idx = IW'(f); ref_write = wr;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
    m_used[f] = 1'b1;
    if (wr) m_dirty[f] = 1'b1;
  endtask

  // Independent model of the search (R3, R4, R5, R7, R8, R9).
  task automatic model_pick(input bit mode, output int v, output bit vd, output int steps);
    int p;
    v = -1; steps = 0;
    if (mode) begin
      for (int i = 0; i < N; i++) begin
        int q;
        q = (m_ptr + i) % N;
        if (!m_used[q] && !m_dirty[q]) begin
          v = q; steps = i; break;
        end
      end
      if (v < 0) steps = N;
    end
    if (v < 0) begin
      p = m_ptr;
      while (m_used[p]) begin
        m_used[p] = 1'b0; p = (p + 1) % N; steps++;
      end
      v = p;
    end
    vd = m_dirty[v];
    m_dirty[v] = 1'b0;
    m_ptr = (v + 1) % N;
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic request(input bit mode, input string tag);
    int v, st; bit vd;
    exp_t e;
    model_pick(mode, v, vd, st);
    e.idx = v; e.dirty = vd; e.cycles = st + 1; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req = 1'b1; prefer_clean = mode;
    @(negedge clk);
    req = 1'b0; prefer_clean = 1'b0;
    wait_empty();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ref_valid = 1'b0; ref_idx = '0; ref_write = 1'b0;
    req = 1'b0; prefer_clean = 1'b0;
    for (int i = 0; i < N; i++) begin m_used[i] = 0; m_dirty[i] = 0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset outputs", int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", int'(busy) + int'(done), 0);

    request(1'b0, "R1 first victim");
    request(1'b0, "R5 next frame");
    use_frame(2, 0); use_frame(3, 0);
    request(1'b0, "R3 second chance");
    use_frame(5, 0); use_frame(6, 0); use_frame(7, 0);
    request(1'b0, "R4 wrap");
    use_frame(1, 1);
    request(1'b0, "R2 written frame skipped");

    // Make every frame unused but modified, then exercise clean-first.
    for (int i = 0; i < N; i++) use_frame(i, 1);
    request(1'b0, "R9 dirty victim");
    request(1'b1, "R7 clean first");
    for (int i = 0; i < N; i++) if (!m_dirty[i]) use_frame(i, 0);
    request(1'b1, "R8 fallback");
    request(1'b1, "R7 clean after fallback");

    // Same-cycle use beats clearing.
    begin
      int p0, v;
      exp_t e;
      for (int i = 0; i < N; i++) use_frame(i, 0);
      p0 = m_ptr;
      v = (p0 + 1) % N;
      e.idx = v; e.dirty = m_dirty[v]; e.cycles = N + 2; e.tag = "R10 use wins";
      sb.push_back(e);
      @(negedge clk);
      req = 1'b1; prefer_clean = 1'b0;
      @(negedge clk);
      req = 1'b0; ref_valid = 1'b1; ref_idx = IW'(p0); ref_write = 1'b0;
      @(negedge clk);
      ref_valid = 1'b0;
      for (int i = 0; i < N; i++) m_used[i] = 1'b0;
      m_dirty[v] = 1'b0;
      m_ptr = (p0 + 2) % N;
      wait_empty();
    end

    // Mixed traffic.
    for (int it = 0; it < 30; it++) begin
      int nref;
      nref = $urandom_range(0, 3);
      for (int k = 0; k < nref; k++) use_frame($urandom_range(0, N - 1), 1'($urandom_range(0, 1)));
      request(1'($urandom_range(0, 1)), "R3 R7 mixed");
    end

    finish_run();
  end
endmodule